// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical frame number by reading a two-level page table held in memory. The logical address is cut into three fields. The top 12 bits index an outer table. The next 10 bits index an inner table page. The low 10 bits are the byte offset inside a 1 KiB page. The outer table starts at a root byte address that is given on an input port. Its entry names the frame that holds the inner table page. The inner entry names the data frame.

A client offers one address at a time through a valid/ready request. The walker fetches the two table entries through a single memory read port. That port has a request handshake and a response valid that may arrive any number of cycles later. The walker then raises a one-cycle response carrying either the frame number and full physical address, or a fault that tells which level held the invalid entry.

Each table entry is 32 bits wide. Bit 0 is its valid flag, and bits 31:10 hold a frame number. The address of an entry is its table base plus four times the index.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk is at `root + 4*vaddr[31:20]`.
- R3: When the outer entry has bit 0 set, the second read is at `{outer_entry[31:10], 10'b0} + 4*vaddr[19:10]`.
- R4: When both entries have bit 0 set, the response has `resp_fault` = 0, `resp_frame` = inner_entry[31:10] and `resp_paddr` = `{inner_entry[31:10], vaddr[9:0]}`.
- R5: An outer entry with bit 0 clear ends the walk with `resp_fault` = 1 and `resp_fault_lvl` = 0, and no second memory read is made.
- R6: An inner entry with bit 0 clear ends the walk with `resp_fault` = 1 and `resp_fault_lvl` = 1.
- R7: `req_ready` stays 0 from the cycle after a request is accepted until the walk's response has been given. A request held during a walk starts no second walk in that time.
- R8: While `mem_req_ready` is 0, `mem_req_valid` stays at 1 and `mem_req_addr` does not change. A `mem_rsp_valid` that arrives when no read is outstanding is ignored.
- R9: `resp_valid` is a single-cycle pulse. It is raised in the cycle right after the clock edge that takes the final memory response.
- R10: `root_base` is sampled when the request is accepted. Changing it later has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 32 | Byte address of the outer table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Walk ended on an invalid entry |
| resp_fault_lvl | output | 1 | Level of the invalid entry: 0 outer, 1 inner |
| resp_frame | output | 22 | Frame number of the translated page |
| resp_paddr | output | 32 | Frame number joined with the page offset |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
Each table read is requested in the cycle after the walker enters the matching read state. The read stays posted until the memory takes it. The response strobe is due exactly one cycle after the memory response that ends the walk. The bench samples at falling edges and keeps a cycle count. It records the cycle in which it presented each real memory response and the cycle in which it saw `resp_valid`, and it requires a difference of one. Further idle cycles after each walk check that the strobe came only once and that no read or walk followed.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   typedef enum logic [2:0] {
      PW_IDLE,
      PW_RD_OUT,
      PW_RD_IN,
      PW_DONE,
      PW_FAULT
   } pw_state_e;

   typedef enum logic {
      PW_LVL_OUTER = 1'b0,
      PW_LVL_INNER = 1'b1
   } pw_lvl_e;
endpackage

// File: rtl/pgwalk_split.sv
module pgwalk_split #(
   parameter int VA_W  = 32,
   parameter int OFS_W = 10,
   parameter int IN_W  = 10
) (
   input  logic [VA_W-1:0]              vaddr,
   output logic [VA_W-OFS_W-IN_W-1:0]   out_idx,
   output logic [IN_W-1:0]              in_idx,
   output logic [OFS_W-1:0]             ofs
);
   localparam int OUT_W = VA_W - OFS_W - IN_W;

   assign out_idx = vaddr[VA_W-1 -: OUT_W];
   assign in_idx  = vaddr[OFS_W +: IN_W];
   assign ofs     = vaddr[OFS_W-1:0];
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int PA_W   = 32,
   parameter int OFS_W  = 10,
   parameter int OUT_W  = 12,
   parameter int IN_W   = 10,
   parameter int PTE_SH = 2
) (
   input  logic [PA_W-1:0]       root,
   input  logic [PA_W-OFS_W-1:0] tbl_frame,
   input  logic [OUT_W-1:0]      out_idx,
   input  logic [IN_W-1:0]       in_idx,
   input  logic                  sel_inner,
   output logic [PA_W-1:0]       addr
);
   logic [PA_W-1:0] out_scaled;
   logic [PA_W-1:0] in_scaled;
   logic [PA_W-1:0] in_base;

   assign out_scaled = PA_W'(out_idx) << PTE_SH;
   assign in_scaled  = PA_W'(in_idx) << PTE_SH;
   assign in_base    = {tbl_frame, {OFS_W{1'b0}}};
   assign addr       = sel_inner ? (in_base + in_scaled) : (root + out_scaled);
endmodule

// File: rtl/pgwalk_pte.sv
module pgwalk_pte #(
   parameter int PTE_W     = 32,
   parameter int FRAME_W   = 22,
   parameter int VALID_BIT = 0
) (
   input  logic [PTE_W-1:0]   pte,
   output logic               ok,
   output logic [FRAME_W-1:0] frame
);
   logic unused_pte_bits;

   assign ok              = pte[VALID_BIT];
   assign frame           = pte[PTE_W-1 -: FRAME_W];
   assign unused_pte_bits = ^pte;
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
   import pgwalk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic pte_ok,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   output logic req_ready,
   output logic mem_req_valid,
   output logic sel_inner,
   output logic take_outer,
   output logic take_inner,
   output logic resp_valid,
   output logic resp_fault,
   output logic fault_lvl
);
   pw_state_e st, st_nxt;
   logic      issued;
   logic      reading;
   logic      got;
   pw_lvl_e   lvl_q;

   assign reading       = (st == PW_RD_OUT) || (st == PW_RD_IN);
   assign got           = reading && issued && mem_rsp_valid;
   assign mem_req_valid = reading && !issued;
   assign req_ready     = (st == PW_IDLE);
   assign sel_inner     = (st == PW_RD_IN);
   assign take_outer    = got && (st == PW_RD_OUT);
   assign take_inner    = got && (st == PW_RD_IN);
   assign resp_valid    = (st == PW_DONE) || (st == PW_FAULT);
   assign resp_fault    = (st == PW_FAULT);
   assign fault_lvl     = lvl_q;

   always_comb begin
      st_nxt = st;
      case (st)
         PW_IDLE:   if (req_valid) st_nxt = PW_RD_OUT;
         PW_RD_OUT: if (got) st_nxt = pte_ok ? PW_RD_IN : PW_FAULT;
         PW_RD_IN:  if (got) st_nxt = pte_ok ? PW_DONE : PW_FAULT;
         PW_DONE:   st_nxt = PW_IDLE;
         PW_FAULT:  st_nxt = PW_IDLE;
         default:   st_nxt = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PW_IDLE;
         issued <= 1'b0;
         lvl_q  <= PW_LVL_OUTER;
      end else begin
         st <= st_nxt;
         if (got) issued <= 1'b0;
         else if (mem_req_valid && mem_req_ready) issued <= 1'b1;
         if (got && !pte_ok) lvl_q <= (st == PW_RD_IN) ? PW_LVL_INNER : PW_LVL_OUTER;
      end
   end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int OFS_W     = 10,
   parameter int IN_W      = 10,
   parameter int PTE_W     = 32,
   parameter int VALID_BIT = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PA_W-1:0]       root_base,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_vaddr,
   output logic                  resp_valid,
   output logic                  resp_fault,
   output logic                  resp_fault_lvl,
   output logic [PA_W-OFS_W-1:0] resp_frame,
   output logic [PA_W-1:0]       resp_paddr,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [PA_W-1:0]       mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [PTE_W-1:0]      mem_rsp_data
);
   localparam int OUT_W     = VA_W - OFS_W - IN_W;
   localparam int FRAME_W   = PA_W - OFS_W;
   localparam int PTE_BYTES = PTE_W / 8;
   localparam int PTE_SH    = $clog2(PTE_BYTES);

   generate
      if (OUT_W < 1) begin : g_bad_split
         $error("pgwalk_top: offset and inner index leave no outer index bits");
      end
      if ((PTE_W % 8 != 0) || ((1 << PTE_SH) != PTE_BYTES)) begin : g_bad_pte_w
         $error("pgwalk_top: entry width must be a power-of-two number of bytes");
      end
      if (PTE_W < FRAME_W + 1) begin : g_bad_pte_fit
         $error("pgwalk_top: entry too narrow for frame number and valid flag");
      end
      if (VALID_BIT >= PTE_W - FRAME_W) begin : g_bad_valid_pos
         $error("pgwalk_top: valid flag overlaps the frame field");
      end
   endgenerate

   logic [VA_W-1:0]    va_q;
   logic [PA_W-1:0]    root_q;
   logic [FRAME_W-1:0] tbl_q;
   logic [FRAME_W-1:0] frm_q;
   logic [OUT_W-1:0]   out_idx;
   logic [IN_W-1:0]    in_idx;
   logic [OFS_W-1:0]   ofs;
   logic               pte_ok;
   logic [FRAME_W-1:0] pte_frame;
   logic               sel_inner;
   logic               take_outer;
   logic               take_inner;

   pgwalk_split #(.VA_W(VA_W), .OFS_W(OFS_W), .IN_W(IN_W)) u_split (
      .vaddr   (va_q),
      .out_idx (out_idx),
      .in_idx  (in_idx),
      .ofs     (ofs)
   );

   pgwalk_addr #(.PA_W(PA_W), .OFS_W(OFS_W), .OUT_W(OUT_W), .IN_W(IN_W), .PTE_SH(PTE_SH)) u_addr (
      .root      (root_q),
      .tbl_frame (tbl_q),
      .out_idx   (out_idx),
      .in_idx    (in_idx),
      .sel_inner (sel_inner),
      .addr      (mem_req_addr)
   );

   pgwalk_pte #(.PTE_W(PTE_W), .FRAME_W(FRAME_W), .VALID_BIT(VALID_BIT)) u_pte (
      .pte   (mem_rsp_data),
      .ok    (pte_ok),
      .frame (pte_frame)
   );

   pgwalk_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .pte_ok        (pte_ok),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .req_ready     (req_ready),
      .mem_req_valid (mem_req_valid),
      .sel_inner     (sel_inner),
      .take_outer    (take_outer),
      .take_inner    (take_inner),
      .resp_valid    (resp_valid),
      .resp_fault    (resp_fault),
      .fault_lvl     (resp_fault_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q   <= '0;
         root_q <= '0;
         tbl_q  <= '0;
         frm_q  <= '0;
      end else begin
         if (req_valid && req_ready) begin
            va_q   <= req_vaddr;
            root_q <= root_base;
         end
         if (take_outer) tbl_q <= pte_frame;
         if (take_inner) frm_q <= pte_frame;
      end
   end

   assign resp_frame = frm_q;
   assign resp_paddr = {frm_q, ofs};
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFS_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            resp_valid,
   input logic            resp_fault,
   input logic [PA_W-1:0] resp_paddr,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr
);
   logic [OFS_W-1:0] ofs_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_seen <= '0;
      else if (req_valid && req_ready) ofs_seen <= req_vaddr[OFS_W-1:0];
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !resp_valid));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R9
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R7
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7
   read_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R4
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_fault) |-> (resp_paddr[OFS_W-1:0] == ofs_seen));
endmodule

bind pgwalk_top pgwalk_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_pgwalk_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_vaddr     (req_vaddr),
   .resp_valid    (resp_valid),
   .resp_fault    (resp_fault),
   .resp_paddr    (resp_paddr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        resp_valid;
   logic        resp_fault;
   logic        resp_fault_lvl;
   logic [21:0] resp_frame;
   logic [31:0] resp_paddr;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   int n_chk = 0;
   int n_fail = 0;

   // memory model state
   logic [31:0] tb_out_addr = '0, tb_in_addr = '0, tb_oe = '0, tb_ie = '0;
   int          lat_cfg = 1;
   int          stall_left = 0;
   int          spur_left = 0;
   int          pend = 0;
   logic [31:0] pend_addr = '0;
   int          nreads = 0;
   logic [31:0] rd_addr [4];
   int          cyc = 0;
   int          last_rsp_cyc = 0;
   int          resp_cnt = 0;
   int          resp_cyc = 0;
   logic        r_fault = 1'b0, r_lvl = 1'b0;
   logic [21:0] r_frame = '0;
   logic [31:0] r_paddr = '0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;
   int          hold_viol = 0;

   always #5 clk = ~clk;

   pgwalk_top i_pgwalk_top (
      .clk            (clk),
      .rst_n          (rst_n),
      .root_base      (root_base),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_vaddr      (req_vaddr),
      .resp_valid     (resp_valid),
      .resp_fault     (resp_fault),
      .resp_fault_lvl (resp_fault_lvl),
      .resp_frame     (resp_frame),
      .resp_paddr     (resp_paddr),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_addr   (mem_req_addr),
      .mem_rsp_valid  (mem_rsp_valid),
      .mem_rsp_data   (mem_rsp_data)
   );

   function automatic logic [31:0] lookup(input logic [31:0] a);
      if (a == tb_out_addr) return tb_oe;
      if (a == tb_in_addr)  return tb_ie;
      return 32'h0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder and output monitor, one process at falling edges
   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         cyc++;
         if (resp_valid) begin
            resp_cnt++;
            resp_cyc = cyc;
            r_fault  = resp_fault;
            r_lvl    = resp_fault_lvl;
            r_frame  = resp_frame;
            r_paddr  = resp_paddr;
         end
         if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_viol++;
         mem_rsp_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = lookup(pend_addr);
               last_rsp_cyc  = cyc;
            end
         end else if (spur_left > 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'h0;
            spur_left--;
         end
         if (stall_left > 0 && mem_req_valid) begin
            mem_req_ready = 1'b0;
            stall_left--;
         end else begin
            mem_req_ready = 1'b1;
         end
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         if (mem_req_valid && mem_req_ready) begin
            if (nreads < 4) rd_addr[nreads] = mem_req_addr;
            nreads++;
            pend_addr = mem_req_addr;
            pend      = lat_cfg;
         end
      end
   end

   task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                           input logic [31:0] oe, input logic [31:0] ie,
                           input int lat, input int stall, input int spur, input bit hold);
      int          c0, t, busy_rdy;
      logic [31:0] eo, ei;
      bit          efault, elvl;
      int          ereads;
      eo     = root + {18'b0, va[31:20], 2'b00};
      ei     = {oe[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
      efault = !oe[0] || !ie[0];
      elvl   = oe[0];
      ereads = oe[0] ? 2 : 1;
      tb_out_addr = eo;
      tb_in_addr  = ei;
      tb_oe       = oe;
      tb_ie       = ie;
      lat_cfg     = lat;
      stall_left  = stall;
      spur_left   = spur;
      nreads      = 0;
      hold_viol   = 0;
      c0          = resp_cnt;
      busy_rdy    = 0;
      @(negedge clk); #1;
      req_valid = 1'b1;
      req_vaddr = va;
      root_base = root;
      @(negedge clk); #1;
      // R10: root changes after acceptance
      root_base = root ^ 32'h00F0_0000;
      if (hold) req_vaddr = ~va;
      else req_valid = 1'b0;
      t = 0;
      while (resp_cnt == c0 && t < 500) begin
         if (req_ready) busy_rdy++;
         @(negedge clk); #1;
         t++;
      end
      req_valid = 1'b0;
      chk(t < 500, "R9 response timeout", 32'(t), 32'd500);
      chk(rd_addr[0] == eo, "R2/R10 outer entry address", rd_addr[0], eo);
      if (oe[0]) chk(rd_addr[1] == ei, "R3 inner entry address", rd_addr[1], ei);
      chk(r_fault == efault, efault ? "R5/R6 fault flag" : "R4 fault flag", 32'(r_fault), 32'(efault));
      if (efault) begin
         chk(r_lvl == elvl, elvl ? "R6 fault level" : "R5 fault level", 32'(r_lvl), 32'(elvl));
      end else begin
         chk(r_frame == ie[31:10], "R4 frame", 32'(r_frame), 32'(ie[31:10]));
         chk(r_paddr == {ie[31:10], va[9:0]}, "R4 paddr", r_paddr, {ie[31:10], va[9:0]});
      end
      chk(resp_cyc == last_rsp_cyc + 1, "R9 response cycle", 32'(resp_cyc - last_rsp_cyc), 32'd1);
      chk(busy_rdy == 0, "R7 ready during walk", 32'(busy_rdy), 32'd0);
      chk(hold_viol == 0, "R8 stalled request held", 32'(hold_viol), 32'd0);
      repeat (4) @(negedge clk);
      #1;
      chk(resp_cnt == c0 + 1, "R9 single response pulse", 32'(resp_cnt - c0), 32'd1);
      chk(nreads == ereads, oe[0] ? "R7 read count" : "R5 read count", 32'(nreads), 32'(ereads));
   endtask

   task automatic test_reset;
      // R1
      chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
      chk(resp_valid == 1'b0, "R1 resp_valid after reset", 32'(resp_valid), 32'd0);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
   endtask

   task automatic test_basic;       // R2 R3 R4 R9
      run_walk(32'h1234_5678, 32'h0010_0000, 32'h0004_5401, 32'hCAFE_F001, 1, 0, 0, 1'b0);
   endtask

   task automatic test_slow_memory; // R8 with stalls and long latency, maximum indices
      run_walk(32'hFFFF_FFFF, 32'h0800_0000, 32'h7FFF_FC01, 32'hFFFF_FC01, 4, 3, 0, 1'b0);
   endtask

   task automatic test_outer_fault; // R5
      run_walk(32'h00A0_1234, 32'h0020_0000, 32'h0003_0000, 32'h1111_1001, 2, 1, 0, 1'b0);
   endtask

   task automatic test_inner_fault; // R6
      run_walk(32'h8765_4321, 32'h0030_0000, 32'h0012_3401, 32'h5555_5400, 1, 0, 0, 1'b0);
   endtask

   task automatic test_busy_hold;   // R7 R10
      run_walk(32'h4000_8ABC, 32'h0040_0000, 32'h0000_0801, 32'h0ABC_D401, 3, 2, 0, 1'b1);
   endtask

   task automatic test_stray_rsp;   // R8 stray responses while idle and during a stall
      run_walk(32'h0ABC_DEF0, 32'h0050_0000, 32'h0009_9C01, 32'h3333_0C01, 2, 3, 3, 1'b0);
   endtask

   task automatic test_zero;        // R2 R4 boundary: all-zero indices and root
      run_walk(32'h0000_0000, 32'h0000_0000, 32'h0000_0401, 32'h0000_0801, 1, 0, 0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_basic();
      test_slow_memory();
      test_outer_fault();
      test_inner_fault();
      test_busy_hold();
      test_stray_rsp();
      test_zero();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule